// File: doc/BRIEF.md
# Rectangle Fill Command Engine

This block takes 64-bit drawing command words on a valid/ready command stream and keeps a small drawing state: a colour index, a start corner, a stop corner, a cursor and a draw mode. When a go command arrives in rectangle mode, it walks the inclusive rectangle between the two corners. For every pixel it issues one write request on a valid/ready pixel stream. Each request carries the byte address of the pixel in a bottom-up, 3-byte-per-pixel frame buffer and the 24-bit colour for the current index.

The colour table lives outside the block. The engine drives the index on `pal_idx` and passes the returned `pal_rgb` straight to the pixel stream. The cursor and draw mode are brought out so that a neighbouring bitmap path can share the decoded state.

Back-pressure rules: a command word transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low for as long as a fill is running, so the sender must hold its word until the fill ends. A pixel transfers on a cycle where `px_valid` and `px_ready` are both high. While `px_valid` is high and `px_ready` is low, the request is held unchanged.

Top module: `rect_fill_engine`

## Requirements
- R1: A word is classified by its field [55:32]. Bits [63:56] are ignored for the three field-matched commands. Field 0x185C04 loads the colour index from bits [19:12], and the index appears on `pal_idx` after the accepting edge.
- R2: Field 0x184604 loads the start corner, with X from bits [31:16] and Y from bits [15:0]. It also moves `cursor_x`/`cursor_y` to that corner.
- R3: Field 0x184704 loads the stop corner from the same bit fields. It leaves the cursor where it is.
- R4: A start or stop coordinate equal to or above the screen width (X) or height (Y) is stored as zero, and this applies to the cursor as well.
- R5: The full word 0x0019100400018000 sets `draw_mode` to 1 (rectangle). The full word 0x0019100400418008 sets it to 2 (bitmap). After reset the mode is 0 (none).
- R6: The full word 0x001C130400000018 is the go command. In rectangle mode it emits one request per pixel with start X ≤ x ≤ stop X and start Y ≤ y ≤ stop Y. Rows go in ascending y, and within a row x ascends.
- R7: The request for pixel (x, y) has `px_addr` = 3·(W·(H−1−y)+x). `px_rgb` carries the palette colour, with red in [23:16], green in [15:8] and blue in [7:0].
- R8: If stop X < start X or stop Y < start Y, a go emits no request and `cmd_ready` stays high.
- R9: A go command while the mode is bitmap or none emits no request and leaves `cmd_ready` high.
- R10: `cmd_ready` is low from the cycle after a go that starts a fill until the last pixel has transferred, and it is high again on the next cycle. While it is low, no state visible at the ports changes.
- R11: While `px_valid` is high and `px_ready` is low, `px_valid` stays high and `px_addr` does not change on the next cycle.
- R12: Any other word, including a go or mode word with a non-zero top byte, changes none of the colour index, corners, cursor or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Engine can take a command (low while filling) |
| cmd_data | input | 64 | Command word |
| pal_idx | output | 8 | Current colour index, to the external colour table |
| pal_rgb | input | 24 | Colour returned for `pal_idx` |
| px_valid | output | 1 | Pixel write request present |
| px_ready | input | 1 | Frame buffer takes the request |
| px_addr | output | $clog2(3·W·H) | Byte address of the pixel |
| px_rgb | output | 24 | Pixel colour, R/G/B from high to low |
| draw_mode | output | 2 | 0 none, 1 rectangle, 2 bitmap |
| cursor_x | output | $clog2(W) | Cursor column |
| cursor_y | output | $clog2(H) | Cursor row |

## Verification
Some properties are checked on every cycle: the handshake invariants (command stream closed while pixels flow, held requests stay stable, no port-visible state change while busy), the bounds of the address and cursor, and the fact that a go outside rectangle mode never starts a fill. The bench scenarios cover what these invariants cannot: the exact set and order of pixels for every corner pair along each axis (including clamped and reversed corners), the address arithmetic, the colour delivered, the decoding of each command field and the rejection of near-miss words.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_COLOR,
    CK_START,
    CK_STOP,
    CK_RECT,
    CK_BITMAP,
    CK_GO
  } cmd_kind_e;

  typedef enum logic [1:0] {
    DM_NONE   = 2'd0,
    DM_RECT   = 2'd1,
    DM_BITMAP = 2'd2
  } draw_mode_e;

  // field-matched opcodes in word[55:32]
  localparam logic [23:0] OP_COLOR = 24'h185C04;
  localparam logic [23:0] OP_START = 24'h184604;
  localparam logic [23:0] OP_STOP  = 24'h184704;

  // whole-word commands
  localparam logic [63:0] WORD_RECT   = 64'h0019100400018000;
  localparam logic [63:0] WORD_BITMAP = 64'h0019100400418008;
  localparam logic [63:0] WORD_GO     = 64'h001C130400000018;

endpackage

// File: rtl/rfe_decode.sv
module rfe_decode
  import rfe_pkg::*;
(
  input  logic [63:0] word,
  output cmd_kind_e   kind
);

  always_comb begin
    if (word == WORD_GO) begin
      kind = CK_GO;
    end else if (word == WORD_RECT) begin
      kind = CK_RECT;
    end else if (word == WORD_BITMAP) begin
      kind = CK_BITMAP;
    end else begin
      case (word[55:32])
        OP_COLOR: kind = CK_COLOR;
        OP_START: kind = CK_START;
        OP_STOP:  kind = CK_STOP;
        default:  kind = CK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rfe_regs.sv
module rfe_regs
  import rfe_pkg::*;
#(
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  cmd_kind_e     kind,
  input  logic [31:0]   word_lo,
  output logic [7:0]    color,
  output logic [XW-1:0] start_x,
  output logic [YW-1:0] start_y,
  output logic [XW-1:0] stop_x,
  output logic [YW-1:0] stop_y,
  output logic [XW-1:0] cur_x,
  output logic [YW-1:0] cur_y,
  output draw_mode_e    mode
);

  logic [XW-1:0] fx;
  logic [YW-1:0] fy;

  // out-of-screen coordinates collapse to zero
  always_comb begin
    fx = (word_lo[31:16] >= 16'(SCR_W)) ? '0 : word_lo[16 +: XW];
    fy = (word_lo[15:0]  >= 16'(SCR_H)) ? '0 : word_lo[0 +: YW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      color   <= '0;
      start_x <= '0;
      start_y <= '0;
      stop_x  <= '0;
      stop_y  <= '0;
      cur_x   <= '0;
      cur_y   <= '0;
      mode    <= DM_NONE;
    end else if (load) begin
      case (kind)
        CK_COLOR: color <= word_lo[19:12];
        CK_START: begin
          start_x <= fx;
          start_y <= fy;
          cur_x   <= fx;
          cur_y   <= fy;
        end
        CK_STOP: begin
          stop_x <= fx;
          stop_y <= fy;
        end
        CK_RECT:   mode <= DM_RECT;
        CK_BITMAP: mode <= DM_BITMAP;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/rfe_scan.sv
module rfe_scan #(
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H),
  localparam int AW = $clog2(3 * SCR_W * SCR_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [XW-1:0] start_x,
  input  logic [YW-1:0] start_y,
  input  logic [XW-1:0] stop_x,
  input  logic [YW-1:0] stop_y,
  input  logic          px_ready,
  output logic          busy,
  output logic [AW-1:0] px_addr
);

  localparam logic [AW-1:0] ROW_BYTES = AW'(3 * SCR_W);

  logic          busy_q;
  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  logic [AW-1:0] row_q;   // byte address of (start_x, y_q)
  logic [AW-1:0] addr_q;  // byte address of (x_q, y_q)
  logic          nonempty;
  logic [AW-1:0] first_addr;
  logic          row_end;
  logic          last_row;

  always_comb begin
    nonempty   = (stop_x >= start_x) && (stop_y >= start_y);
    first_addr = AW'(YW'(SCR_H - 1) - start_y) * ROW_BYTES
               + AW'(start_x) + AW'(start_x) + AW'(start_x);
    row_end    = (x_q == stop_x);
    last_row   = (y_q == stop_y);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      row_q  <= '0;
      addr_q <= '0;
    end else if (!busy_q) begin
      if (launch && nonempty) begin
        busy_q <= 1'b1;
        x_q    <= start_x;
        y_q    <= start_y;
        row_q  <= first_addr;
        addr_q <= first_addr;
      end
    end else if (px_ready) begin
      if (!row_end) begin
        x_q    <= x_q + 1'b1;
        addr_q <= addr_q + AW'(3);
      end else if (last_row) begin
        busy_q <= 1'b0;
      end else begin
        x_q    <= start_x;
        y_q    <= y_q + 1'b1;
        row_q  <= row_q - ROW_BYTES;
        addr_q <= row_q - ROW_BYTES;
      end
    end
  end

  assign busy    = busy_q;
  assign px_addr = addr_q;

endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H),
  localparam int AW = $clog2(3 * SCR_W * SCR_H)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [63:0]   cmd_data,
  output logic [7:0]    pal_idx,
  input  logic [23:0]   pal_rgb,
  output logic          px_valid,
  input  logic          px_ready,
  output logic [AW-1:0] px_addr,
  output logic [23:0]   px_rgb,
  output logic [1:0]    draw_mode,
  output logic [XW-1:0] cursor_x,
  output logic [YW-1:0] cursor_y
);

  cmd_kind_e     kind;
  draw_mode_e    mode;
  logic          busy;
  logic          accept;
  logic          launch;
  logic [XW-1:0] sx, ex;
  logic [YW-1:0] sy, ey;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign launch    = accept && (kind == CK_GO) && (mode == DM_RECT);

  rfe_decode u_dec (
    .word (cmd_data),
    .kind (kind)
  );

  rfe_regs #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .kind    (kind),
    .word_lo (cmd_data[31:0]),
    .color   (pal_idx),
    .start_x (sx),
    .start_y (sy),
    .stop_x  (ex),
    .stop_y  (ey),
    .cur_x   (cursor_x),
    .cur_y   (cursor_y),
    .mode    (mode)
  );

  rfe_scan #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .start_x  (sx),
    .start_y  (sy),
    .stop_x   (ex),
    .stop_y   (ey),
    .px_ready (px_ready),
    .busy     (busy),
    .px_addr  (px_addr)
  );

  assign px_valid  = busy;
  assign px_rgb    = pal_rgb;
  assign draw_mode = mode;

endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int SCR_W = 1280,
  parameter int SCR_H = 1024,
  localparam int XW = $clog2(SCR_W),
  localparam int YW = $clog2(SCR_H),
  localparam int AW = $clog2(3 * SCR_W * SCR_H)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [63:0]   cmd_data,
  input logic [7:0]    pal_idx,
  input logic          px_valid,
  input logic          px_ready,
  input logic [AW-1:0] px_addr,
  input logic [1:0]    draw_mode,
  input logic [XW-1:0] cursor_x,
  input logic [YW-1:0] cursor_y
);

  localparam logic [63:0] GO_WORD = 64'h001C130400000018;

  AST_BUSY_CLOSES_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> !cmd_ready);  // R10

  AST_BUSY_FREEZES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> ($stable(pal_idx) && $stable(draw_mode)
                    && $stable(cursor_x) && $stable(cursor_y)));  // R10

  AST_PX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> (px_valid && $stable(px_addr)));  // R11

  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid |-> (({1'b0, px_addr} < (AW+1)'(3 * SCR_W * SCR_H))
                  && ((px_addr % AW'(3)) == '0)));  // R7

  AST_CURSOR_ON_SCREEN: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cursor_x) < SCR_W) && (32'(cursor_y) < SCR_H));  // R4

  AST_GO_NEEDS_RECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_data == GO_WORD) && (draw_mode != 2'd1))
      |=> (cmd_ready && !px_valid));  // R9

  AST_MODE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    draw_mode != 2'd3);  // R5

endmodule

bind rect_fill_engine rfe_checker #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_data  (cmd_data),
  .pal_idx   (pal_idx),
  .px_valid  (px_valid),
  .px_ready  (px_ready),
  .px_addr   (px_addr),
  .draw_mode (draw_mode),
  .cursor_x  (cursor_x),
  .cursor_y  (cursor_y)
);

// File: tb/sim_rect_fill_engine.sv
`timescale 1ns/1ps
module sim_rect_fill_engine;

  localparam int W  = 12;
  localparam int H  = 6;
  localparam int XW = $clog2(W);
  localparam int YW = $clog2(H);
  localparam int AW = $clog2(3 * W * H);

  localparam logic [23:0] T_COLOR = 24'h185C04;
  localparam logic [23:0] T_START = 24'h184604;
  localparam logic [23:0] T_STOP  = 24'h184704;
  localparam logic [63:0] T_RECT  = 64'h0019100400018000;
  localparam logic [63:0] T_BMP   = 64'h0019100400418008;
  localparam logic [63:0] T_GO    = 64'h001C130400000018;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [63:0]   cmd_data = '0;
  logic [7:0]    pal_idx;
  logic [23:0]   pal_rgb;
  logic          px_valid;
  logic          px_ready = 1'b0;
  logic [AW-1:0] px_addr;
  logic [23:0]   px_rgb;
  logic [1:0]    draw_mode;
  logic [XW-1:0] cursor_x;
  logic [YW-1:0] cursor_y;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  function automatic logic [23:0] pal_of(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction
  assign pal_rgb = pal_of(pal_idx);

  rect_fill_engine #(.SCR_W(W), .SCR_H(H)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .px_valid(px_valid), .px_ready(px_ready), .px_addr(px_addr),
    .px_rgb(px_rgb), .draw_mode(draw_mode), .cursor_x(cursor_x),
    .cursor_y(cursor_y)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected fill walk
  int  e_sx, e_sy, e_ex, e_ey, e_x, e_y, seen;
  logic [7:0] e_col;
  int  cyc = 0;
  bit  stall = 1'b0;
  bit  hold_pend = 1'b0;
  logic [AW-1:0] hold_addr;

  always @(negedge clk) begin
    cyc++;
    if (hold_pend)
      check(px_valid && px_addr == hold_addr, "R11 held request", px_addr, hold_addr);
    px_ready = stall ? 1'b0 : ((cyc % 4) != 3);
    if (px_valid && px_ready) begin
      int ea;
      ea = 3 * (W * (H - 1 - e_y) + e_x);
      check(int'(px_addr) == ea, "R7 address", px_addr, ea);
      check(px_rgb == pal_of(e_col), "R7 colour", px_rgb, pal_of(e_col));
      check(!cmd_ready, "R10 ready low while filling", cmd_ready, 0);
      check(e_y <= e_ey, "R6 pixel beyond rectangle", e_y, e_ey);
      seen++;
      if (e_x == e_ex) begin e_x = e_sx; e_y++; end
      else e_x++;
    end
    hold_pend = px_valid && !px_ready;
    hold_addr = px_addr;
  end

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = w;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [63:0] pt_word(input logic [23:0] op, input int x, input int y,
                                          input logic [7:0] top);
    return {top, op, 16'(x), 16'(y)};
  endfunction

  function automatic logic [63:0] col_word(input logic [7:0] idx, input logic [7:0] top);
    return {top, T_COLOR, 12'hFED, idx, 12'h321};
  endfunction

  function automatic int clampc(input int v, input int lim);
    return (v >= lim) ? 0 : v;
  endfunction

  task automatic wait_idle(input string tag);
    int t = 0;
    while (!cmd_ready && t < 2000) begin @(negedge clk); t++; end
    check(cmd_ready, tag, cmd_ready, 1);
  endtask

  // full fill: corners given raw, expectations from clamped values
  task automatic do_fill(input int sx, input int sy, input int ex, input int ey,
                         input logic [7:0] col, input string tag);
    int cnt;
    send(col_word(col, 8'h00));
    send(pt_word(T_START, sx, sy, 8'h3C));
    send(pt_word(T_STOP, ex, ey, 8'hC3));
    e_sx = clampc(sx, W); e_sy = clampc(sy, H);
    e_ex = clampc(ex, W); e_ey = clampc(ey, H);
    e_x = e_sx; e_y = e_sy; e_col = col; seen = 0;
    cnt = (e_ex >= e_sx && e_ey >= e_sy) ? (e_ex - e_sx + 1) * (e_ey - e_sy + 1) : 0;
    send(T_GO);
    if (cnt == 0) check(cmd_ready, "R8 empty go keeps ready", cmd_ready, 1);
    else          check(!cmd_ready, "R10 ready drops after go", cmd_ready, 0);
    wait_idle("R10 ready returns");
    check(seen == cnt, tag, seen, cnt);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(cmd_ready == 1 && px_valid == 0, "R10 reset handshake", {cmd_ready, px_valid}, 2'b10);
    check(draw_mode == 2'd0, "R5 reset mode none", draw_mode, 0);
    check(cursor_x == 0 && cursor_y == 0 && pal_idx == 0, "R2 reset state", {cursor_x, cursor_y}, 0);

    // go with no mode selected
    send(pt_word(T_START, 1, 1, 8'h00));
    send(pt_word(T_STOP, 3, 2, 8'h00));
    seen = 0;
    send(T_GO);
    repeat (4) @(negedge clk);
    check(seen == 0 && cmd_ready, "R9 go in mode none", seen, 0);

    // colour field with junk top byte
    send(col_word(8'hB7, 8'hFF));
    check(pal_idx == 8'hB7, "R1 colour index", pal_idx, 8'hB7);
    check(px_rgb == pal_of(8'hB7), "R7 colour passes through", px_rgb, pal_of(8'hB7));

    // start moves cursor, stop does not
    send(pt_word(T_START, 5, 3, 8'h81));
    check(cursor_x == 5 && cursor_y == 3, "R2 cursor to start", {cursor_x, cursor_y}, {4'd5, 3'd3});
    send(pt_word(T_STOP, 9, 4, 8'h42));
    check(cursor_x == 5 && cursor_y == 3, "R3 stop leaves cursor", {cursor_x, cursor_y}, {4'd5, 3'd3});
    send(pt_word(T_START, W + 7, H, 8'h00));
    check(cursor_x == 0 && cursor_y == 0, "R4 clamp start", {cursor_x, cursor_y}, 0);
    send(pt_word(T_START, W - 1, H - 1, 8'h00));
    check(cursor_x == W - 1 && cursor_y == H - 1, "R4 edge kept", {cursor_x, cursor_y}, {4'(W - 1), 3'(H - 1)});

    // bitmap mode: go does nothing
    send(T_BMP);
    check(draw_mode == 2'd2, "R5 bitmap mode", draw_mode, 2);
    seen = 0;
    send(T_GO);
    repeat (4) @(negedge clk);
    check(seen == 0 && cmd_ready, "R9 go in bitmap mode", seen, 0);

    // near-miss words leave state unchanged
    send(T_RECT | 64'h0100000000000000);
    check(draw_mode == 2'd2, "R12 top byte on mode word", draw_mode, 2);
    send({8'h00, 24'h185C05, 12'h000, 8'h11, 12'h000});
    check(pal_idx == 8'hB7, "R12 near colour field", pal_idx, 8'hB7);
    send({8'h00, 24'h184605, 16'd2, 16'd2});
    check(cursor_x == W - 1 && cursor_y == H - 1, "R12 near start field", {cursor_x, cursor_y}, {4'(W - 1), 3'(H - 1)});
    send(T_GO | 64'h8000000000000000);
    repeat (3) @(negedge clk);
    check(cmd_ready && draw_mode == 2'd2, "R12 top byte on go", draw_mode, 2);

    send(T_RECT);
    check(draw_mode == 2'd1, "R5 rectangle mode", draw_mode, 1);

    // command held off during a fill
    do_fill(2, 1, 6, 3, 8'h20, "R6 pixel count");
    send(pt_word(T_START, 0, 0, 8'h00));
    send(pt_word(T_STOP, W - 1, H - 1, 8'h00));
    e_sx = 0; e_sy = 0; e_ex = W - 1; e_ey = H - 1; e_x = 0; e_y = 0; e_col = 8'hB7; seen = 0;
    send(col_word(8'hB7, 8'h00));
    send(T_GO);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = col_word(8'h44, 8'h00);
    stall = 1'b1;
    repeat (5) @(negedge clk);
    check(px_valid && !cmd_ready, "R11 stalled request", px_valid, 1);
    stall = 1'b0;
    while (!cmd_ready) begin
      if (pal_idx != 8'hB7) check(0, "R10 command taken while busy", pal_idx, 8'hB7);
      @(negedge clk);
    end
    check(seen == W * H, "R6 full screen", seen, W * H);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(pal_idx == 8'h44, "R10 held command taken after fill", pal_idx, 8'h44);

    // sweep X corners (including clamped and reversed), fixed rows
    for (int sx = 0; sx <= W + 1; sx++)
      for (int ex = 0; ex <= W + 1; ex++)
        do_fill(sx, 1, ex, 3, 8'(sx * 16 + ex), "R6 x sweep count");
    // sweep Y corners, fixed columns
    for (int sy = 0; sy <= H; sy++)
      for (int ey = 0; ey <= H; ey++)
        do_fill(2, sy, 5, ey, 8'(sy * 8 + ey), "R8 y sweep count");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule